// File: doc/BRIEF.md
# Unified Translation Lookaside Search

This block is a small, fully associative translation table that is searched with a composed virtual address. The lookup side forms an 88-bit virtual tag from a guest-state bit, an 8-bit partition number, an address-space bit and a 14-bit process number, placed ahead of a 64-bit effective address. The address-space bit follows the fetch-space control bit for instruction fetches and the data-space control bit for loads and stores. Every resident entry is compared with this tag at the same time. An entry's size code masks the low effective-address bits out of the comparison, so pages of any supported size can sit in the table together.

Each entry is either a direct mapping or an indirect pointer meant for a hardware table walker. The type bit only decides which group an entry belongs to and takes no part in the compare. A lookup returns one of three results: a direct hit with a 42-bit real address, an indirect hit carrying the entry number and its stored pointer for the walker, or a miss marked as either instruction or data. Software fills the table through a synchronous write port. The result comes out of a register one cycle after the request.

Top module: `xlat_lookup`

## Requirements
- R1: A synchronous reset clears every result output to zero and marks every entry invalid, so a lookup issued after reset and before any write is a miss.
- R2: An entry matches only if its guest bit, partition number and process number all equal the request's context. A difference in any one of them prevents the hit.
- R3: For a fetch (`lk_fetch`=1) the address-space bit compared is `msr_is`. For a load or store (`lk_fetch`=0) it is `msr_ds`.
- R4: Size codes for direct pages are 0=4 KB (12 offset bits), 1=64 KB (16), 2=1 MB (20), 3=16 MB (24) and 4=1 GB (30). Codes 6 and 7 act as 4 KB. Address bits below the page offset are left out of the compare. The real address takes the stored real page bits above the offset and the effective-address bits below it.
- R5: When any valid direct entry matches, the result is a direct hit, whatever the entry indices are. Entries with the same tag match whether they are direct or indirect.
- R6: Indirect entries use code 2 (1 MB) or code 5 (256 MB, 28 offset bits). When no direct entry matches but an indirect one does, `res_indirect` is set, `res_idx` is the lowest matching indirect index, and `res_ra` is that entry's stored real field unchanged.
- R7: When nothing matches, `res_imiss` is set for a fetch and `res_dmiss` is set for a load or store.
- R8: When several direct entries match, the lowest index is returned and `res_multi` is set. `res_multi` is zero for any other result.
- R9: `res_valid` is set exactly one cycle after `lk_valid`. When `res_valid` is clear, every result flag, `res_idx` and `res_ra` are zero. On a miss, `res_idx` and `res_ra` are zero.
- R10: A write takes effect for lookups in the following cycle. A lookup in the same cycle as a write sees the old contents.
- R11: Each valid result carries exactly one of `res_direct`, `res_indirect`, `res_imiss` and `res_dmiss`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request strobe |
| lk_fetch | input | 1 | 1 = instruction fetch, 0 = load/store |
| lk_ea | input | 64 | Effective address |
| ctx_gs | input | 1 | Guest-state bit of the request |
| ctx_lpid | input | 8 | Partition number of the request |
| ctx_pid | input | 14 | Process number of the request |
| msr_is | input | 1 | Address-space bit used for fetches |
| msr_ds | input | 1 | Address-space bit used for data accesses |
| wr_en | input | 1 | Entry write strobe |
| wr_idx | input | IDX_W | Entry index to write |
| wr_vld | input | 1 | Valid bit written |
| wr_ind | input | 1 | 1 = indirect entry, 0 = direct |
| wr_gs | input | 1 | Guest-state tag written |
| wr_lpid | input | 8 | Partition tag written |
| wr_as | input | 1 | Address-space tag written |
| wr_pid | input | 14 | Process tag written |
| wr_size | input | 3 | Page size code written |
| wr_epn | input | 64 | Effective page address written |
| wr_rpn | input | 42 | Real page address or walker pointer written |
| res_valid | output | 1 | Result strobe |
| res_direct | output | 1 | Direct hit |
| res_indirect | output | 1 | Indirect hit |
| res_imiss | output | 1 | Instruction miss |
| res_dmiss | output | 1 | Data miss |
| res_multi | output | 1 | More than one direct entry matched |
| res_idx | output | IDX_W | Index of the chosen entry |
| res_ra | output | 42 | Translated real address or indirect pointer |

## Verification
The first lookups land in an empty table, so only misses can occur and the instruction and data flavours are checked separately. Pages of every direct size are then installed and probed inside their boundaries and one page past them. This separates a correct offset mask from an off-by-one size. Next, the context fields and the two address-space controls are changed one at a time while the address stays fixed, which shows that each tag field takes part in the compare. Overlapping direct and indirect entries are placed so that the indirect entry sometimes has the lower index, which shows that type priority wins over index order. The last tests are same-cycle writes and a random mix of sizes and contexts, each compared against a behavioural model on every clock.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  localparam int EA_W   = 64;
  localparam int RA_W   = 42;
  localparam int LPID_W = 8;
  localparam int PID_W  = 14;
  localparam int SZ_W   = 3;

  // composed virtual tag: context fields ahead of the effective address
  typedef struct packed {
    logic              gs;
    logic [LPID_W-1:0] lpid;
    logic              as_id;
    logic [PID_W-1:0]  pid;
    logic [EA_W-1:0]   ea;
  } xlat_va_t;

  typedef struct packed {
    logic              vld;
    logic              ind;
    logic              gs;
    logic [LPID_W-1:0] lpid;
    logic              as_id;
    logic [PID_W-1:0]  pid;
    logic [SZ_W-1:0]   size;
    logic [EA_W-1:0]   epn;
    logic [RA_W-1:0]   rpn;
  } xlat_entry_t;

  // ones above the page offset, zeros inside it
  function automatic logic [EA_W-1:0] page_mask(input logic [SZ_W-1:0] code);
    logic [5:0] sh;
    case (code)
      3'd0:    sh = 6'd12;
      3'd1:    sh = 6'd16;
      3'd2:    sh = 6'd20;
      3'd3:    sh = 6'd24;
      3'd4:    sh = 6'd30;
      3'd5:    sh = 6'd28;
      default: sh = 6'd12;
    endcase
    return {EA_W{1'b1}} << sh;
  endfunction

endpackage

// File: rtl/xlat_va_build.sv
module xlat_va_build
  import xlat_pkg::*;
(
  input  logic              fetch_i,
  input  logic              msr_is_i,
  input  logic              msr_ds_i,
  input  logic              gs_i,
  input  logic [LPID_W-1:0] lpid_i,
  input  logic [PID_W-1:0]  pid_i,
  input  logic [EA_W-1:0]   ea_i,
  output xlat_va_t          va_o
);

  always_comb begin
    va_o.gs    = gs_i;
    va_o.lpid  = lpid_i;
    va_o.as_id = fetch_i ? msr_is_i : msr_ds_i;
    va_o.pid   = pid_i;
    va_o.ea    = ea_i;
  end

endmodule

// File: rtl/xlat_entry_store.sv
module xlat_entry_store
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int IDX_W   = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en_i,
  input  logic [IDX_W-1:0]          wr_idx_i,
  input  xlat_entry_t               wr_entry_i,
  output xlat_entry_t [ENTRIES-1:0] tbl_o
);

  xlat_entry_t [ENTRIES-1:0] tbl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) tbl_q[i].vld <= 1'b0;
    end else if (wr_en_i && (int'(wr_idx_i) < ENTRIES)) begin
      tbl_q[wr_idx_i] <= wr_entry_i;
    end
  end

  assign tbl_o = tbl_q;

endmodule

// File: rtl/xlat_match_array.sv
module xlat_match_array
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 16
) (
  input  xlat_va_t                  va_i,
  input  xlat_entry_t [ENTRIES-1:0] tbl_i,
  output logic [ENTRIES-1:0]        dir_hit_o,
  output logic [ENTRIES-1:0]        ind_hit_o
);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    logic [EA_W-1:0] keep;
    logic            ctx_eq;
    logic            addr_eq;
    logic            hit;

    always_comb begin
      keep    = page_mask(tbl_i[g].size);
      ctx_eq  = (tbl_i[g].gs    == va_i.gs)   &&
                (tbl_i[g].lpid  == va_i.lpid) &&
                (tbl_i[g].as_id == va_i.as_id)&&
                (tbl_i[g].pid   == va_i.pid);
      addr_eq = ((tbl_i[g].epn ^ va_i.ea) & keep) == '0;
      hit     = tbl_i[g].vld && ctx_eq && addr_eq;
    end

    // the type bit only sorts the hit into its group
    assign dir_hit_o[g] = hit && !tbl_i[g].ind;
    assign ind_hit_o[g] = hit &&  tbl_i[g].ind;
  end

endmodule

// File: rtl/xlat_pick.sv
module xlat_pick #(
  parameter int ENTRIES = 16,
  parameter int IDX_W   = 4
) (
  input  logic [ENTRIES-1:0] hit_i,
  output logic               any_o,
  output logic               multi_o,
  output logic [IDX_W-1:0]   idx_o
);

  always_comb begin
    any_o   = |hit_i;
    multi_o = (hit_i & (hit_i - 1'b1)) != '0;
    idx_o   = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hit_i[i]) idx_o = IDX_W'(i);
    end
  end

endmodule

// File: rtl/xlat_lookup.sv
module xlat_lookup
  import xlat_pkg::*;
#(
  parameter  int ENTRIES = 16,
  localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_valid,
  input  logic              lk_fetch,
  input  logic [EA_W-1:0]   lk_ea,
  input  logic              ctx_gs,
  input  logic [LPID_W-1:0] ctx_lpid,
  input  logic [PID_W-1:0]  ctx_pid,
  input  logic              msr_is,
  input  logic              msr_ds,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_vld,
  input  logic              wr_ind,
  input  logic              wr_gs,
  input  logic [LPID_W-1:0] wr_lpid,
  input  logic              wr_as,
  input  logic [PID_W-1:0]  wr_pid,
  input  logic [SZ_W-1:0]   wr_size,
  input  logic [EA_W-1:0]   wr_epn,
  input  logic [RA_W-1:0]   wr_rpn,
  output logic              res_valid,
  output logic              res_direct,
  output logic              res_indirect,
  output logic              res_imiss,
  output logic              res_dmiss,
  output logic              res_multi,
  output logic [IDX_W-1:0]  res_idx,
  output logic [RA_W-1:0]   res_ra
);

  xlat_va_t                  va;
  xlat_entry_t               wr_entry;
  xlat_entry_t [ENTRIES-1:0] tbl;
  logic [ENTRIES-1:0]        dir_hit, ind_hit;
  logic                      d_any, d_multi, i_any, i_multi_unused;
  logic [IDX_W-1:0]          d_idx, i_idx;
  logic [EA_W-1:0]           d_keep;
  logic [RA_W-1:0]           d_ra, i_ra;

  always_comb begin
    wr_entry.vld   = wr_vld;
    wr_entry.ind   = wr_ind;
    wr_entry.gs    = wr_gs;
    wr_entry.lpid  = wr_lpid;
    wr_entry.as_id = wr_as;
    wr_entry.pid   = wr_pid;
    wr_entry.size  = wr_size;
    wr_entry.epn   = wr_epn;
    wr_entry.rpn   = wr_rpn;
  end

  xlat_va_build u_va (
    .fetch_i (lk_fetch),
    .msr_is_i(msr_is),
    .msr_ds_i(msr_ds),
    .gs_i    (ctx_gs),
    .lpid_i  (ctx_lpid),
    .pid_i   (ctx_pid),
    .ea_i    (lk_ea),
    .va_o    (va)
  );

  xlat_entry_store #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_store (
    .clk       (clk),
    .rst       (rst),
    .wr_en_i   (wr_en),
    .wr_idx_i  (wr_idx),
    .wr_entry_i(wr_entry),
    .tbl_o     (tbl)
  );

  xlat_match_array #(.ENTRIES(ENTRIES)) u_match (
    .va_i     (va),
    .tbl_i    (tbl),
    .dir_hit_o(dir_hit),
    .ind_hit_o(ind_hit)
  );

  xlat_pick #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_pick_dir (
    .hit_i  (dir_hit),
    .any_o  (d_any),
    .multi_o(d_multi),
    .idx_o  (d_idx)
  );

  xlat_pick #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_pick_ind (
    .hit_i  (ind_hit),
    .any_o  (i_any),
    .multi_o(i_multi_unused),
    .idx_o  (i_idx)
  );

  // real address: stored page bits above the offset, request bits below
  always_comb begin
    d_keep = page_mask(tbl[d_idx].size);
    d_ra   = (tbl[d_idx].rpn & d_keep[RA_W-1:0]) |
             (lk_ea[RA_W-1:0] & ~d_keep[RA_W-1:0]);
    i_ra   = tbl[i_idx].rpn;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid    <= 1'b0;
      res_direct   <= 1'b0;
      res_indirect <= 1'b0;
      res_imiss    <= 1'b0;
      res_dmiss    <= 1'b0;
      res_multi    <= 1'b0;
      res_idx      <= '0;
      res_ra       <= '0;
    end else begin
      res_valid    <= lk_valid;
      res_direct   <= lk_valid && d_any;
      res_indirect <= lk_valid && !d_any && i_any;
      res_imiss    <= lk_valid && !d_any && !i_any && lk_fetch;
      res_dmiss    <= lk_valid && !d_any && !i_any && !lk_fetch;
      res_multi    <= lk_valid && d_any && d_multi;
      if (lk_valid && d_any) begin
        res_idx <= d_idx;
        res_ra  <= d_ra;
      end else if (lk_valid && i_any) begin
        res_idx <= i_idx;
        res_ra  <= i_ra;
      end else begin
        res_idx <= '0;
        res_ra  <= '0;
      end
    end
  end

endmodule

// File: rtl/xlat_lookup_chk.sv
module xlat_lookup_chk (
  input logic clk,
  input logic rst,
  input logic lk_valid,
  input logic lk_fetch,
  input logic res_valid,
  input logic res_direct,
  input logic res_indirect,
  input logic res_imiss,
  input logic res_dmiss,
  input logic res_multi
);

  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> !res_valid && !res_direct && !res_indirect && !res_imiss && !res_dmiss && !res_multi);

  a_r9_valid_follows: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> res_valid);

  a_r9_idle_follows: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !res_valid);

  a_r9_flags_need_valid: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> !(res_direct || res_indirect || res_imiss || res_dmiss || res_multi));

  a_r11_one_outcome: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> $countones({res_direct, res_indirect, res_imiss, res_dmiss}) == 1);

  a_r7_imiss_is_fetch: assert property (@(posedge clk) disable iff (rst)
    res_imiss |-> $past(lk_fetch));

  a_r7_dmiss_is_data: assert property (@(posedge clk) disable iff (rst)
    res_dmiss |-> !$past(lk_fetch));

  a_r8_multi_only_direct: assert property (@(posedge clk) disable iff (rst)
    res_multi |-> res_direct);

endmodule

bind xlat_lookup xlat_lookup_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .lk_valid    (lk_valid),
  .lk_fetch    (lk_fetch),
  .res_valid   (res_valid),
  .res_direct  (res_direct),
  .res_indirect(res_indirect),
  .res_imiss   (res_imiss),
  .res_dmiss   (res_dmiss),
  .res_multi   (res_multi)
);

// File: tb/test_xlat_lookup.sv
module test_xlat_lookup;

  localparam int N  = 16;
  localparam int IW = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lk_valid = 0, lk_fetch = 0;
  logic [63:0] lk_ea = '0;
  logic        ctx_gs = 0;
  logic [7:0]  ctx_lpid = 8'h05;
  logic [13:0] ctx_pid = 14'h123;
  logic        msr_is = 0, msr_ds = 0;
  logic        wr_en = 0, wr_vld = 0, wr_ind = 0, wr_gs = 0, wr_as = 0;
  logic [IW-1:0] wr_idx = '0;
  logic [7:0]  wr_lpid = '0;
  logic [13:0] wr_pid = '0;
  logic [2:0]  wr_size = '0;
  logic [63:0] wr_epn = '0;
  logic [41:0] wr_rpn = '0;
  logic        res_valid, res_direct, res_indirect, res_imiss, res_dmiss, res_multi;
  logic [IW-1:0] res_idx;
  logic [41:0] res_ra;

  always #2 clk = ~clk;

  xlat_lookup #(.ENTRIES(N)) i_xlat_lookup (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_fetch(lk_fetch), .lk_ea(lk_ea),
    .ctx_gs(ctx_gs), .ctx_lpid(ctx_lpid), .ctx_pid(ctx_pid), .msr_is(msr_is), .msr_ds(msr_ds),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_vld(wr_vld), .wr_ind(wr_ind), .wr_gs(wr_gs),
    .wr_lpid(wr_lpid), .wr_as(wr_as), .wr_pid(wr_pid), .wr_size(wr_size), .wr_epn(wr_epn),
    .wr_rpn(wr_rpn), .res_valid(res_valid), .res_direct(res_direct), .res_indirect(res_indirect),
    .res_imiss(res_imiss), .res_dmiss(res_dmiss), .res_multi(res_multi), .res_idx(res_idx),
    .res_ra(res_ra)
  );

  // behavioural model of the table
  bit          m_vld [N];
  bit          m_ind [N];
  bit          m_gs  [N];
  int          m_lpid[N];
  bit          m_as  [N];
  int          m_pid [N];
  int          m_size[N];
  logic [63:0] m_epn [N];
  logic [41:0] m_rpn [N];

  bit          e_v, e_d, e_i, e_im, e_dm, e_m;
  int          e_idx;
  logic [41:0] e_ra;

  int    checks = 0, fails = 0;
  bit    finished = 0;
  string cur_req = "R1";

  function automatic int offset_bits(int code);
    case (code)
      1: return 16;
      2: return 20;
      3: return 24;
      4: return 30;
      5: return 28;
      default: return 12;
    endcase
  endfunction

  task automatic predict();
    int first_d, first_i, nd, sh;
    bit as_sel;
    logic [63:0] r;
    e_v = 0; e_d = 0; e_i = 0; e_im = 0; e_dm = 0; e_m = 0; e_idx = 0; e_ra = '0;
    if (lk_valid) begin
      first_d = -1; first_i = -1; nd = 0;
      as_sel = lk_fetch ? msr_is : msr_ds;
      for (int i = 0; i < N; i++) begin
        sh = offset_bits(m_size[i]);
        if (m_vld[i] && m_gs[i] == ctx_gs && m_lpid[i] == int'(ctx_lpid) &&
            m_as[i] == as_sel && m_pid[i] == int'(ctx_pid) &&
            ((m_epn[i] ^ lk_ea) >> sh) == 64'd0) begin
          if (!m_ind[i]) begin
            if (first_d < 0) first_d = i;
            nd++;
          end else if (first_i < 0) first_i = i;
        end
      end
      e_v = 1;
      if (first_d >= 0) begin
        e_d = 1; e_idx = first_d; e_m = (nd > 1);
        sh = offset_bits(m_size[first_d]);
        r = {22'd0, m_rpn[first_d]};
        r = ((r >> sh) << sh) | (lk_ea & ((64'd1 << sh) - 64'd1));
        e_ra = r[41:0];
      end else if (first_i >= 0) begin
        e_i = 1; e_idx = first_i; e_ra = m_rpn[first_i];
      end else if (lk_fetch) e_im = 1;
      else e_dm = 1;
    end
  endtask

  task automatic compare();
    checks++;
    if (res_valid !== e_v || res_direct !== e_d || res_indirect !== e_i ||
        res_imiss !== e_im || res_dmiss !== e_dm || res_multi !== e_m ||
        int'(res_idx) != e_idx || res_ra !== e_ra) begin
      fails++;
      $display("FAIL %s: got v%0b d%0b i%0b im%0b dm%0b m%0b idx%0d ra=%h expected v%0b d%0b i%0b im%0b dm%0b m%0b idx%0d ra=%h",
               cur_req, res_valid, res_direct, res_indirect, res_imiss, res_dmiss, res_multi,
               res_idx, res_ra, e_v, e_d, e_i, e_im, e_dm, e_m, e_idx, e_ra);
    end
  endtask

  // one clock: predict from the old table, then record the write, then check
  task automatic cycle();
    predict();
    if (wr_en && int'(wr_idx) < N) begin
      m_vld[wr_idx] = wr_vld; m_ind[wr_idx] = wr_ind; m_gs[wr_idx] = wr_gs;
      m_lpid[wr_idx] = int'(wr_lpid); m_as[wr_idx] = wr_as; m_pid[wr_idx] = int'(wr_pid);
      m_size[wr_idx] = int'(wr_size); m_epn[wr_idx] = wr_epn; m_rpn[wr_idx] = wr_rpn;
    end
    @(negedge clk);
    compare();
  endtask

  task automatic set_wr(int idx, bit v, bit ind, bit as, int size, logic [63:0] epn, logic [41:0] rpn);
    wr_en = 1; wr_idx = IW'(idx); wr_vld = v; wr_ind = ind; wr_gs = 0; wr_lpid = 8'h05;
    wr_as = as; wr_pid = 14'h123; wr_size = 3'(size); wr_epn = epn; wr_rpn = rpn;
  endtask

  task automatic put(int idx, bit v, bit ind, bit as, int size, logic [63:0] epn, logic [41:0] rpn);
    set_wr(idx, v, ind, as, size, epn, rpn);
    cycle();
    wr_en = 0;
  endtask

  task automatic look(bit fetch, logic [63:0] ea);
    lk_valid = 1; lk_fetch = fetch; lk_ea = ea;
    cycle();
    lk_valid = 0;
  endtask

  task automatic finish_up();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL R9: watchdog expired, got running expected done");
      finish_up();
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      m_vld[i] = 0; m_ind[i] = 0; m_gs[i] = 0; m_lpid[i] = 0; m_as[i] = 0;
      m_pid[i] = 0; m_size[i] = 0; m_epn[i] = '0; m_rpn[i] = '0;
    end
    lk_valid = 1;
    repeat (3) @(negedge clk);
    cur_req = "R1";
    e_v = 0; e_d = 0; e_i = 0; e_im = 0; e_dm = 0; e_m = 0; e_idx = 0; e_ra = '0;
    compare();
    lk_valid = 0;
    rst = 0;

    // R1 / R7: empty table misses in both flavours
    look(0, 64'h0000_0000_0000_1000);
    cur_req = "R7";
    look(1, 64'h0000_0000_0000_0000);
    look(0, 64'hFFFF_FFFF_FFFF_FFFF);

    // R9: idle cycles yield an all-zero result
    cur_req = "R9";
    cycle(); cycle();

    // R4: every direct size, inside and just past the page
    cur_req = "R4";
    put(0, 1, 0, 0, 0, 64'h0000_0040_1234_5000, 42'h0AB_CDEF_0000);
    look(0, 64'h0000_0040_1234_5ABC);
    look(0, 64'h0000_0040_1234_6000);
    put(1, 1, 0, 0, 1, 64'h0000_0050_0001_0000, 42'h3FF_FFFF_FFFF);
    look(0, 64'h0000_0050_0001_FFFF);
    look(0, 64'h0000_0050_0002_0000);
    put(2, 1, 0, 0, 2, 64'h0000_0051_0030_0000, 42'h155_5555_5555);
    look(0, 64'h0000_0051_003A_BCDE);
    look(0, 64'h0000_0051_0040_0000);
    put(3, 1, 0, 0, 3, 64'h0000_0052_0500_0000, 42'h0C0_0000_0000);
    look(1, 64'h0000_0052_05FF_FFFF);
    look(1, 64'h0000_0052_0600_0000);
    put(4, 1, 0, 0, 4, 64'h0000_0053_4000_0000, 42'h2AA_AAAA_AAAA);
    look(0, 64'h0000_0053_7FFF_0001);
    look(0, 64'h0000_0053_8000_0000);

    // R2: each context field alone blocks the hit
    cur_req = "R2";
    ctx_gs = 1;      look(0, 64'h0000_0040_1234_5ABC); ctx_gs = 0;
    ctx_lpid = 8'h06; look(0, 64'h0000_0040_1234_5ABC); ctx_lpid = 8'h05;
    ctx_pid = 14'h124; look(0, 64'h0000_0040_1234_5ABC); ctx_pid = 14'h123;
    look(0, 64'h0000_0040_1234_5ABC);

    // R3: address-space bit source depends on the access kind
    cur_req = "R3";
    put(5, 1, 0, 1, 0, 64'h0000_0060_0000_0000, 42'h011_1111_1000);
    look(0, 64'h0000_0060_0000_0123);
    msr_ds = 1; look(0, 64'h0000_0060_0000_0123);
    look(1, 64'h0000_0060_0000_0123);
    msr_is = 1; look(1, 64'h0000_0060_0000_0123);
    msr_ds = 0; look(0, 64'h0000_0060_0000_0123);
    msr_is = 0;

    // R5: direct wins over indirect whatever the indices
    cur_req = "R5";
    put(6, 1, 1, 0, 5, 64'h0000_0070_0000_0000, 42'h123_4560_0000);
    put(7, 1, 0, 0, 2, 64'h0000_0070_0010_0000, 42'h0F0_0000_0000);
    look(0, 64'h0000_0070_0012_3456);
    look(1, 64'h0000_0070_001F_FFFF);

    // R6: indirect hits when no direct entry matches
    cur_req = "R6";
    look(0, 64'h0000_0070_0FFF_0000);
    put(7, 0, 0, 0, 2, 64'h0000_0070_0010_0000, 42'h0F0_0000_0000);
    look(0, 64'h0000_0070_0012_3456);
    put(8, 1, 1, 0, 2, 64'h0000_0071_0020_0000, 42'h0AA_0000_1234);
    look(1, 64'h0000_0071_002F_0000);
    look(1, 64'h0000_0071_0030_0000);

    // R8: overlapping direct pages
    cur_req = "R8";
    put(9, 1, 0, 0, 4, 64'h0000_0090_0000_0000, 42'h100_0000_0000);
    put(10, 1, 0, 0, 0, 64'h0000_0090_0000_3000, 42'h222_2222_2000);
    look(0, 64'h0000_0090_0000_3010);
    look(0, 64'h0000_0090_0020_0000);

    // R10: a write lands after the lookup of the same cycle
    cur_req = "R10";
    set_wr(11, 1, 0, 0, 1, 64'h0000_00A0_0000_0000, 42'h033_0000_0000);
    lk_valid = 1; lk_fetch = 0; lk_ea = 64'h0000_00A0_0000_0042;
    cycle();
    wr_en = 0;
    cycle();
    set_wr(11, 0, 0, 0, 1, 64'h0000_00A0_0000_0000, 42'h033_0000_0000);
    cycle();
    wr_en = 0;
    cycle();
    lk_valid = 0;

    // R11: random mix of sizes, types and contexts
    cur_req = "R11";
    for (int k = 0; k < 400; k++) begin
      logic [63:0] ea;
      ea = {32'h0000_00A5, 2'b00, 2'($urandom), 28'($urandom)};
      if (($urandom % 3) == 0) begin
        set_wr(int'($urandom % N), 1'($urandom % 4 != 0), 1'($urandom % 3 == 0),
               1'($urandom), int'($urandom % 8), ea, 42'({$urandom, $urandom}));
        wr_gs = 1'($urandom % 4 == 0);
      end
      lk_valid = 1'($urandom % 4 != 0);
      lk_fetch = 1'($urandom);
      lk_ea = {32'h0000_00A5, 2'b00, 2'($urandom), 28'($urandom)};
      ctx_gs = 1'($urandom % 4 == 0);
      msr_is = 1'($urandom); msr_ds = 1'($urandom);
      cycle();
      wr_en = 0;
    end
    lk_valid = 0;
    cycle();
    finish_up();
  end

endmodule